// File: doc/BRIEF.md
# Sixteen-Sample Rank-Label Median Unit

This block finds the median of a group of up to sixteen samples. Samples arrive one per cycle on a serial input and are written into a sixteen-slot register bank. Once the group is complete, every pair of slots is compared at the same time and the comparison results are registered. Each slot's results are then summed into a rank label from 0 to 15. Ties are broken by slot index, so no two slots share a label.

A multiplexer picks the two slots whose labels sit on either side of the middle. Their sum is kept with fractional bits, which gives the average of the two samples as a fixed-point median. A half-group mode reuses the same comparator and rank hardware for eight samples. In that mode the eight unused slots are preset to the largest code, and only the label pair that the multiplexer selects is changed.

The control is a six-state machine:
- S_IDLE: waits for `grp_start`. Taking `grp_start` presets the bank and leads to S_LOAD.
- S_LOAD: takes samples. Writing the last sample leads to S_CMP.
- S_CMP: registers the comparison matrix, then moves to S_RANK.
- S_RANK: registers the rank labels, then moves to S_PICK.
- S_PICK: registers the two selected samples, then moves to S_AVG.
- S_AVG: registers the result and its valid pulse, then returns to S_IDLE.

Top module: `rank_median16`

## Requirements
- R1: Reset leaves `med_valid` at 0, `busy` at 0 and `med_data` at 0.
- R2: In S_IDLE, `grp_start` latches `half_mode`, presets every bank slot to all ones and raises `busy` on the next cycle.
- R3: In S_LOAD, a sample is taken only in a cycle with `smp_valid` high, into consecutive slots starting at slot 0. Cycles with `smp_valid` low take no sample and do not advance the slot count.
- R4: Rank labels are unique. Slot i ranks above slot j when its value is larger, or when the values are equal and i > j.
- R5: With `half_mode` = 0, a group is 16 samples and the result is built from the samples labelled 7 and 8.
- R6: With `half_mode` = 1, a group is 8 samples. Slots 8 to 15 keep the all-ones preset, and the result is built from the samples labelled 3 and 4.
- R7: `med_data` is (lo + hi) shifted left by FRAC-1. This is the average of the two selected samples with FRAC = 6 fractional bits, in DW+FRAC bits.
- R8: `med_valid` is a one-cycle pulse that rises on the fourth rising edge after the edge that takes the last sample. `busy` is low from that cycle on.
- R9: `grp_start` while `busy` is high has no effect: the mode and the load position of the running group are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_start | input | 1 | Opens a new group when idle |
| half_mode | input | 1 | 1 = eight-sample group, 0 = sixteen-sample group; sampled with grp_start |
| smp_valid | input | 1 | Qualifies smp_data during loading |
| smp_data | input | DW (16) | Unsigned sample |
| busy | output | 1 | High from group start until the result cycle |
| med_valid | output | 1 | One-cycle result strobe |
| med_data | output | DW+FRAC (22) | Median, unsigned fixed point with FRAC fractional bits |

## Verification
Groups are tried in both modes. The bench uses ascending, descending and all-equal data, data with many repeated values, all-ones samples that tie with the preset fill, and wide random data. Sorted input tells apart the choice of label pair. Heavy ties and all-ones data expose a broken tie rule or a wrong fill value. Groups loaded with idle gaps, and groups that receive a second start while loading, show whether the slot count and the mode are held. The median and the timing of the strobe are checked for every group.

// File: rtl/rank_median_pkg.sv
package rank_median_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_LOAD = 3'd1,
        S_CMP  = 3'd2,
        S_RANK = 3'd3,
        S_PICK = 3'd4,
        S_AVG  = 3'd5
    } med_state_e;

    // Lower label of the middle pair, for a given number of valid entries.
    function automatic int mid_low_label(input int valid_cnt);
        return valid_cnt / 2 - 1;
    endfunction

endpackage

// File: rtl/med_slot_bank.sv
module med_slot_bank #(
    parameter int DW = 16,
    parameter int NS = 16,
    localparam int IW = $clog2(NS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   preset,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  logic [DW-1:0]          wr_data,
    output logic [NS-1:0][DW-1:0]  slots
);

    for (genvar s = 0; s < NS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots[s] <= '0;
            end else if (preset) begin
                slots[s] <= '1;
            end else if (wr_en && (wr_idx == IW'(s))) begin
                slots[s] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/med_rank_matrix.sv
module med_rank_matrix #(
    parameter int DW = 16,
    parameter int NS = 16,
    localparam int RW = $clog2(NS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmp_en,
    input  logic                   rank_en,
    input  logic                   check_en,
    input  logic [NS-1:0][DW-1:0]  slots,
    output logic [NS-1:0][RW-1:0]  ranks
);

    logic [NS-1:0][NS-1:0] beat_d, beat_q;
    logic [NS-1:0][RW-1:0] rank_d;
    logic [NS-1:0]         label_seen;

    // beat[i][j] = slot i ranks above slot j (ties go to the higher index)
    always_comb begin
        for (int i = 0; i < NS; i++) begin
            for (int j = 0; j < NS; j++) begin
                if (i == j)
                    beat_d[i][j] = 1'b0;
                else if (i > j)
                    beat_d[i][j] = (slots[i] >= slots[j]);
                else
                    beat_d[i][j] = (slots[i] > slots[j]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            beat_q <= '0;
        else if (cmp_en)
            beat_q <= beat_d;
    end

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            rank_d[i] = '0;
            for (int j = 0; j < NS; j++)
                rank_d[i] = rank_d[i] + RW'(beat_q[i][j]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ranks <= '0;
        else if (rank_en)
            ranks <= rank_d;
    end

    always_comb begin
        label_seen = '0;
        for (int i = 0; i < NS; i++)
            label_seen[ranks[i]] = 1'b1;
    end

    // R4: every label 0..NS-1 appears exactly once once ranks are ready
    assert_ranks_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
        check_en |-> (&label_seen));

endmodule

// File: rtl/med_pick_avg.sv
module med_pick_avg #(
    parameter int DW   = 16,
    parameter int NS   = 16,
    parameter int FRAC = 6,
    localparam int RW  = $clog2(NS),
    localparam int OW  = DW + FRAC
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   half_q,
    input  logic                   pick_en,
    input  logic                   avg_en,
    input  logic [NS-1:0][DW-1:0]  slots,
    input  logic [NS-1:0][RW-1:0]  ranks,
    output logic [OW-1:0]          med_out
);

    import rank_median_pkg::*;

    localparam logic [RW-1:0] LO_FULL = RW'(mid_low_label(NS));
    localparam logic [RW-1:0] LO_HALF = RW'(mid_low_label(NS / 2));

    logic [RW-1:0] lo_lbl, hi_lbl;
    logic [DW-1:0] lo_d, hi_d, lo_q, hi_q;
    logic [DW:0]   pair_sum;

    // remapped selection table: mode picks the label pair
    always_comb begin
        lo_lbl = half_q ? LO_HALF : LO_FULL;
        hi_lbl = lo_lbl + RW'(1);
    end

    always_comb begin
        lo_d = '0;
        hi_d = '0;
        for (int i = 0; i < NS; i++) begin
            if (ranks[i] == lo_lbl) lo_d = lo_d | slots[i];
            if (ranks[i] == hi_lbl) hi_d = hi_d | slots[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (pick_en) begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign pair_sum = {1'b0, lo_q} + {1'b0, hi_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            med_out <= '0;
        else if (avg_en)
            med_out <= OW'(pair_sum) << (FRAC - 1);
    end

    // R5: lower-labelled pick never exceeds the upper one
    assert_pick_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        avg_en |-> (lo_q <= hi_q));

    // R7: result never exceeds the largest code scaled by the fraction
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        avg_en |=> (med_out <= (OW'({DW{1'b1}}) << FRAC)));

endmodule

// File: rtl/rank_median16.sv
module rank_median16 #(
    parameter int DW   = 16,
    parameter int NS   = 16,
    parameter int FRAC = 6,
    localparam int RW  = $clog2(NS),
    localparam int OW  = DW + FRAC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grp_start,
    input  logic          half_mode,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    output logic          busy,
    output logic          med_valid,
    output logic [OW-1:0] med_data
);

    import rank_median_pkg::*;

    localparam logic [RW-1:0] LAST_FULL = RW'(NS - 1);
    localparam logic [RW-1:0] LAST_HALF = RW'(NS / 2 - 1);

    med_state_e state, state_nx;
    logic [RW-1:0] slot_cnt;
    logic          half_q;
    logic          last_smp;
    logic          preset, load_en, cmp_en, rank_en, pick_en, avg_en;
    logic [NS-1:0][DW-1:0] slots;
    logic [NS-1:0][RW-1:0] ranks;

    assign last_smp = smp_valid && (slot_cnt == (half_q ? LAST_HALF : LAST_FULL));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (grp_start) state_nx = S_LOAD;
            S_LOAD: if (last_smp)  state_nx = S_CMP;
            S_CMP:  state_nx = S_RANK;
            S_RANK: state_nx = S_PICK;
            S_PICK: state_nx = S_AVG;
            S_AVG:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        preset  = 1'b0;
        load_en = 1'b0;
        cmp_en  = 1'b0;
        rank_en = 1'b0;
        pick_en = 1'b0;
        avg_en  = 1'b0;
        busy    = 1'b1;
        unique case (state)
            S_IDLE: begin busy = 1'b0; preset = grp_start; end
            S_LOAD: load_en = smp_valid;
            S_CMP:  cmp_en  = 1'b1;
            S_RANK: rank_en = 1'b1;
            S_PICK: pick_en = 1'b1;
            S_AVG:  avg_en  = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_cnt  <= '0;
            half_q    <= 1'b0;
            med_valid <= 1'b0;
        end else begin
            med_valid <= avg_en;
            if (preset) begin
                slot_cnt <= '0;
                half_q   <= half_mode;
            end else if (load_en) begin
                slot_cnt <= slot_cnt + RW'(1);
            end
        end
    end

    med_slot_bank #(.DW(DW), .NS(NS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (preset),
        .wr_en   (load_en),
        .wr_idx  (slot_cnt),
        .wr_data (smp_data),
        .slots   (slots)
    );

    med_rank_matrix #(.DW(DW), .NS(NS)) u_rank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_en   (cmp_en),
        .rank_en  (rank_en),
        .check_en (pick_en),
        .slots    (slots),
        .ranks    (ranks)
    );

    med_pick_avg #(.DW(DW), .NS(NS), .FRAC(FRAC)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_q  (half_q),
        .pick_en (pick_en),
        .avg_en  (avg_en),
        .slots   (slots),
        .ranks   (ranks),
        .med_out (med_data)
    );

    // R8: strobe lasts a single cycle
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        med_valid |=> !med_valid);

    // R8: busy is already low when the result is presented
    assert_idle_on_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        med_valid |-> !busy);

    // R9: a start during a running group leaves mode untouched
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && grp_start) |=> (half_q == $past(half_q)));

    // R3: in half mode the load position never passes the last valid slot
    assert_half_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD && half_q) |-> (slot_cnt <= LAST_HALF));

endmodule

// File: tb/test_rank_median16.sv
module test_rank_median16;

    localparam int DW = 16;
    localparam int FRAC = 6;
    localparam int OW = DW + FRAC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          grp_start = 1'b0;
    logic          half_mode = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          busy, med_valid;
    logic [OW-1:0] med_data;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rank_median16 #(.DW(DW), .NS(16), .FRAC(FRAC)) i_rank_median16 (
        .clk(clk), .rst_n(rst_n), .grp_start(grp_start), .half_mode(half_mode),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .busy(busy), .med_valid(med_valid), .med_data(med_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] expect_median(input int vals[16], input bit half);
        int s[16];
        int n;
        int t;
        n = half ? 8 : 16;
        for (int i = 0; i < 16; i++) s[i] = vals[i];
        for (int i = 0; i < n; i++)
            for (int j = 0; j < n - 1 - i; j++)
                if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
        return OW'(longint'(s[n/2-1]) + longint'(s[n/2])) << (FRAC - 1);
    endfunction

    // gap: idle cycles after each sample; mid_start: extra start during load
    task automatic run_group(input int vals[16], input bit half, input int gap,
                             input bit mid_start, input string req);
        int n;
        logic [OW-1:0] exp_med;
        n = half ? 8 : 16;
        exp_med = expect_median(vals, half);
        grp_start = 1'b1;
        half_mode = half;
        @(negedge clk);
        grp_start = 1'b0;
        half_mode = ~half;
        check("R2 busy after start", busy, 1'b1);
        for (int k = 0; k < n; k++) begin
            smp_valid = 1'b1;
            smp_data  = DW'(vals[k]);
            @(negedge clk);
            if (k != n - 1) begin
                for (int g = 0; g < gap; g++) begin
                    smp_valid = 1'b0;
                    smp_data  = 16'hdead;
                    if (mid_start && k == 4 && g == 0) grp_start = 1'b1;
                    @(negedge clk);
                    grp_start = 1'b0;
                end
            end
        end
        smp_valid = 1'b0;
        for (int c = 1; c <= 3; c++) begin
            @(negedge clk);
            check("R8 no early valid", med_valid, 1'b0);
        end
        check("R8 busy before result", busy, 1'b1);
        @(negedge clk);
        check("R8 valid on fourth edge", med_valid, 1'b1);
        check("R8 busy low at result", busy, 1'b0);
        check(req, med_data, exp_med);
        @(negedge clk);
        check("R8 single pulse", med_valid, 1'b0);
    endtask

    initial begin
        int v[16];
        repeat (3) @(negedge clk);
        check("R1 reset valid", med_valid, 1'b0);
        check("R1 reset busy", busy, 1'b0);
        check("R1 reset data", med_data, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 ascending and descending full groups
        for (int i = 0; i < 16; i++) v[i] = i * 100 + 3;
        run_group(v, 1'b0, 0, 1'b0, "R5 ascending");
        for (int i = 0; i < 16; i++) v[i] = 60000 - i * 7;
        run_group(v, 1'b0, 0, 1'b0, "R5 descending");
        // R6 half groups, sorted
        for (int i = 0; i < 16; i++) v[i] = i * 11;
        run_group(v, 1'b1, 0, 1'b0, "R6 half ascending");
        for (int i = 0; i < 16; i++) v[i] = 900 - i * 13;
        run_group(v, 1'b1, 0, 1'b0, "R6 half descending");
        // R4 all equal, R6 all-ones samples tying with fill
        for (int i = 0; i < 16; i++) v[i] = 4242;
        run_group(v, 1'b0, 0, 1'b0, "R4 all equal");
        for (int i = 0; i < 16; i++) v[i] = 65535;
        run_group(v, 1'b1, 0, 1'b0, "R6 half all ones");
        run_group(v, 1'b0, 0, 1'b0, "R7 full all ones max code");
        // R3 gaps, R9 start during loading
        for (int i = 0; i < 16; i++) v[i] = (i * 37) % 23;
        run_group(v, 1'b0, 2, 1'b0, "R3 full with gaps");
        run_group(v, 1'b1, 1, 1'b1, "R9 half with mid start");
        run_group(v, 1'b0, 1, 1'b1, "R9 full with mid start");

        // R4 heavy ties and wide random, both modes
        for (int r = 0; r < 240; r++) begin
            for (int i = 0; i < 16; i++)
                v[i] = (r % 3 == 0) ? int'($urandom % 4) : int'($urandom % 65536);
            run_group(v, r[0], r % 3, 1'b0, (r % 3 == 0) ? "R4 ties" : "R7 random median");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule